// File: doc/BRIEF.md
# Privilege-Aware Interrupt Take Decision

This block decides, from the hart's present state alone, whether an interrupt should be taken now, which interrupt it is, and which privilege mode handles it. It combines the per-source pending and enable vectors with the machine delegation mask. It then applies a global enable whose meaning depends on where the hart runs compared with the mode each interrupt is aimed at. Last, it picks one source by a fixed priority among the six standard sources: external, software and timer, at both machine and supervisor level.

The global bits only guard interrupts aimed at the mode the hart is in now. An interrupt aimed at a more privileged mode is always allowed through. An interrupt aimed at a less privileged mode is never taken. Code at a higher level that wants to hold off a source while a lower level runs must clear that source's own enable bit. The block has no clock and no state. Its outputs follow its inputs in the same cycle. The trap-entry sequencer samples them together with the rest of the trap decision. Every pin is a plain control level, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_take_decider`

## Requirements
- R1: The machine-level enable is 1 whenever `cur_priv` is below M (values 2'b00 and 2'b01). With `cur_priv` = 2'b11 it equals `mstatus_mie`. Undelegated sources (deleg bit 0) are candidates only while this enable is 1.
- R2: The supervisor-level enable is 1 when `cur_priv` = 2'b00 (U) and equals `sstatus_sie` when `cur_priv` = 2'b01 (S). Delegated sources (deleg bit 1) are candidates only while this enable is 1.
- R3: A source is considered only when its bit is set in both `irq_pending` and `irq_enable`.
- R4: In S-mode, an enabled undelegated pending standard source is taken with target M even when `mstatus_mie` and `sstatus_sie` are both 0.
- R5: In M-mode a delegated source is never taken, whatever the global bits are.
- R6: `sstatus_sie` has no effect on the outputs while `cur_priv` is U or M.
- R7: If any undelegated candidate exists, it is chosen and `target_priv` = 2'b11. Otherwise a delegated candidate is chosen and `target_priv` = 2'b01.
- R8: Within the chosen group, the cause is the first candidate in the order 11, 3, 7, 9, 1, 5, reported as a 4-bit cause number.
- R9: With no candidate, `take_irq` = 0 and `irq_cause` and `target_priv` are both zero.
- R10: Source bits outside positions {1,3,5,7,9,11} are never selected and never block a standard source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_priv | input | 2 | Current privilege: U=2'b00, S=2'b01, M=2'b11 |
| mstatus_mie | input | 1 | Machine global interrupt enable |
| sstatus_sie | input | 1 | Supervisor global interrupt enable |
| irq_pending | input | 16 | Per-source pending bits, bit index = cause number |
| irq_enable | input | 16 | Per-source enable bits |
| irq_deleg | input | 16 | Per-source delegation to S (1 = delegated) |
| take_irq | output | 1 | An interrupt should be taken now |
| irq_cause | output | 4 | Cause number of the chosen source |
| target_priv | output | 2 | Mode that handles it (2'b11 or 2'b01), zero when idle |

## Verification
Directed patterns set a single source in each privilege with the global bits off and on. This separates the forced-on path for more privileged targets from the bit-gated path for the current mode, and shows that interrupts aimed below the current mode are blocked. Mixed undelegated and delegated sources check group precedence. Stacks of sources within one group check the fixed rank order. Sources that are pending but not enabled, and bits outside the standard set, show that neither can be selected. A long stretch of sparse pseudo-random vectors across all four privilege codes is then checked against a behavioural model, which reaches the mixed combinations that the directed cases do not list.

// File: rtl/irq_take_pkg.sv
package irq_take_pkg;

  typedef enum logic [1:0] {
    PRIV_U    = 2'b00,
    PRIV_S    = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_M    = 2'b11
  } priv_e;

  localparam int unsigned NUM_STD = 6;

  // Rank 0 is the highest priority; values are cause numbers.
  localparam int unsigned STD_ORDER [NUM_STD] = '{11, 3, 7, 9, 1, 5};

  function automatic logic [63:0] std_mask64();
    logic [63:0] m;
    m = '0;
    for (int k = 0; k < int'(NUM_STD); k++) begin
      m[STD_ORDER[k]] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_global_enable.sv
module irq_global_enable
  import irq_take_pkg::*;
(
  input  logic [1:0] cur_priv,
  input  logic       mstatus_mie,
  input  logic       sstatus_sie,
  output logic       m_glb_en,
  output logic       s_glb_en
);

  logic below_m;
  logic below_s;
  logic at_m;
  logic at_s;

  always_comb begin
    below_m = (cur_priv < PRIV_M);
    below_s = (cur_priv < PRIV_S);
    at_m    = (cur_priv == PRIV_M);
    at_s    = (cur_priv == PRIV_S);
  end

  always_comb begin
    m_glb_en = below_m | (at_m & mstatus_mie);
    s_glb_en = below_s | (at_s & sstatus_sie);
  end

  // The enable for the current mode is forced when the hart runs below it.
  always_comb begin
    if (cur_priv == PRIV_U) begin
      assert_u_forces_both_R1: assert (m_glb_en && s_glb_en)
        else $error("U-mode must open both global enables");
    end
    if (cur_priv == PRIV_M) begin
      assert_m_closes_s_R5: assert (!s_glb_en)
        else $error("M-mode must close the supervisor enable");
    end
  end

endmodule

// File: rtl/irq_candidate_mask.sv
module irq_candidate_mask #(
  parameter int unsigned NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ-1:0] irq_enable,
  input  logic [NUM_IRQ-1:0] irq_deleg,
  input  logic               m_glb_en,
  input  logic               s_glb_en,
  output logic [NUM_IRQ-1:0] m_cand,
  output logic [NUM_IRQ-1:0] s_cand
);

  import irq_take_pkg::*;

  localparam logic [63:0]        STD_MASK64 = std_mask64();
  localparam logic [NUM_IRQ-1:0] STD_MASK   = STD_MASK64[NUM_IRQ-1:0];

  logic [NUM_IRQ-1:0] live;

  for (genvar i = 0; i < int'(NUM_IRQ); i++) begin : g_bit
    always_comb begin
      live[i]   = irq_pending[i] & irq_enable[i] & STD_MASK[i];
      m_cand[i] = live[i] & ~irq_deleg[i] & m_glb_en;
      s_cand[i] = live[i] &  irq_deleg[i] & s_glb_en;
    end
  end

  always_comb begin
    assert_groups_disjoint_R7: assert ((m_cand & s_cand) == '0)
      else $error("a source sits in both groups");
    assert_gated_by_enable_R3: assert (((m_cand | s_cand) & ~irq_enable) == '0)
      else $error("candidate without its enable bit");
  end

endmodule

// File: rtl/irq_priority_pick.sv
module irq_priority_pick #(
  parameter int unsigned NUM_IRQ = 16,
  localparam int unsigned CAUSE_W = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] cand,
  output logic               found,
  output logic [CAUSE_W-1:0] cause,
  output logic               stray
);

  import irq_take_pkg::*;

  localparam logic [63:0]        STD_MASK64 = std_mask64();
  localparam logic [NUM_IRQ-1:0] STD_MASK   = STD_MASK64[NUM_IRQ-1:0];

  logic [NUM_STD-1:0] hit;
  logic [NUM_STD:0]   seen;

  assign seen[0] = 1'b0;

  for (genvar k = 0; k < int'(NUM_STD); k++) begin : g_rank
    assign hit[k]      = cand[STD_ORDER[k]] & ~seen[k];
    assign seen[k + 1] = seen[k] | cand[STD_ORDER[k]];
  end

  always_comb begin
    cause = '0;
    for (int k = 0; k < int'(NUM_STD); k++) begin
      if (hit[k]) cause = cause | CAUSE_W'(STD_ORDER[k]);
    end
  end

  assign found = seen[NUM_STD];
  assign stray = |(cand & ~STD_MASK);

  always_comb begin
    assert_one_winner_R8: assert ($onehot0(hit))
      else $error("more than one rank selected");
    assert_found_matches_R9: assert (found == (|hit))
      else $error("found flag disagrees with rank hits");
  end

endmodule

// File: rtl/irq_take_decider.sv
module irq_take_decider #(
  parameter int unsigned NUM_IRQ = 16,
  localparam int unsigned CAUSE_W = $clog2(NUM_IRQ)
) (
  input  logic [1:0]         cur_priv,
  input  logic               mstatus_mie,
  input  logic               sstatus_sie,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ-1:0] irq_enable,
  input  logic [NUM_IRQ-1:0] irq_deleg,
  output logic               take_irq,
  output logic [CAUSE_W-1:0] irq_cause,
  output logic [1:0]         target_priv
);

  import irq_take_pkg::*;

  logic               m_glb_en;
  logic               s_glb_en;
  logic [NUM_IRQ-1:0] m_cand;
  logic [NUM_IRQ-1:0] s_cand;
  logic               m_found;
  logic               s_found;
  logic [CAUSE_W-1:0] m_cause;
  logic [CAUSE_W-1:0] s_cause;
  logic               m_stray;
  logic               s_stray;

  irq_global_enable u_glb (
    .cur_priv    (cur_priv),
    .mstatus_mie (mstatus_mie),
    .sstatus_sie (sstatus_sie),
    .m_glb_en    (m_glb_en),
    .s_glb_en    (s_glb_en)
  );

  irq_candidate_mask #(.NUM_IRQ(NUM_IRQ)) u_mask (
    .irq_pending (irq_pending),
    .irq_enable  (irq_enable),
    .irq_deleg   (irq_deleg),
    .m_glb_en    (m_glb_en),
    .s_glb_en    (s_glb_en),
    .m_cand      (m_cand),
    .s_cand      (s_cand)
  );

  irq_priority_pick #(.NUM_IRQ(NUM_IRQ)) u_pick_m (
    .cand  (m_cand),
    .found (m_found),
    .cause (m_cause),
    .stray (m_stray)
  );

  irq_priority_pick #(.NUM_IRQ(NUM_IRQ)) u_pick_s (
    .cand  (s_cand),
    .found (s_found),
    .cause (s_cause),
    .stray (s_stray)
  );

  // Undelegated group wins outright over the delegated group.
  always_comb begin
    take_irq    = 1'b0;
    irq_cause   = '0;
    target_priv = 2'b00;
    if (m_found) begin
      take_irq    = 1'b1;
      irq_cause   = m_cause;
      target_priv = PRIV_M;
    end else if (s_found) begin
      take_irq    = 1'b1;
      irq_cause   = s_cause;
      target_priv = PRIV_S;
    end
  end

  always_comb begin
    assert_idle_zero_R9: assert (take_irq || (irq_cause == '0 && target_priv == 2'b00))
      else $error("idle outputs not zero");
    assert_no_stray_R10: assert (!m_stray && !s_stray)
      else $error("non-standard source reached a picker");
    if (take_irq) begin
      assert_source_live_R3: assert (irq_pending[irq_cause] && irq_enable[irq_cause])
        else $error("taken source not pending and enabled");
      assert_target_matches_deleg_R7: assert (
          (target_priv == PRIV_M && !irq_deleg[irq_cause]) ||
          (target_priv == PRIV_S &&  irq_deleg[irq_cause]))
        else $error("target disagrees with delegation");
    end
    if (cur_priv == PRIV_M && take_irq) begin
      assert_never_lower_R5: assert (target_priv == PRIV_M)
        else $error("interrupt aimed below M taken in M");
    end
    if (cur_priv == PRIV_S && |m_cand) begin
      assert_s_forced_up_R4: assert (take_irq && target_priv == PRIV_M)
        else $error("undelegated source not taken in S");
    end
  end

endmodule

// File: tb/irq_take_decider_bench.sv
module irq_take_decider_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int N_RANDOM   = 4000;

  logic        clk = 1'b0;
  logic [1:0]  cur_priv = 2'b00;
  logic        mstatus_mie = 1'b0;
  logic        sstatus_sie = 1'b0;
  logic [15:0] irq_pending = '0;
  logic [15:0] irq_enable = '0;
  logic [15:0] irq_deleg = '0;
  logic        take_irq;
  logic [3:0]  irq_cause;
  logic [1:0]  target_priv;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_take_decider u_irq_take_decider (
    .cur_priv    (cur_priv),
    .mstatus_mie (mstatus_mie),
    .sstatus_sie (sstatus_sie),
    .irq_pending (irq_pending),
    .irq_enable  (irq_enable),
    .irq_deleg   (irq_deleg),
    .take_irq    (take_irq),
    .irq_cause   (irq_cause),
    .target_priv (target_priv)
  );

  // Behavioural reference.
  task automatic model(output logic t, output logic [3:0] c, output logic [1:0] g);
    int order [6] = '{11, 3, 7, 9, 1, 5};
    bit men;
    bit sen;
    men = (cur_priv != 2'b11) || mstatus_mie;
    sen = (cur_priv == 2'b00) || (cur_priv == 2'b01 && sstatus_sie);
    t = 1'b0; c = 4'd0; g = 2'b00;
    for (int i = 0; i < 6; i++) begin
      if (!t && men && irq_pending[order[i]] && irq_enable[order[i]] && !irq_deleg[order[i]]) begin
        t = 1'b1; c = 4'(order[i]); g = 2'b11;
      end
    end
    for (int i = 0; i < 6; i++) begin
      if (!t && sen && irq_pending[order[i]] && irq_enable[order[i]] && irq_deleg[order[i]]) begin
        t = 1'b1; c = 4'(order[i]); g = 2'b01;
      end
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic mi, input logic si,
                       input logic [15:0] pe, input logic [15:0] en, input logic [15:0] dl);
    @(posedge clk);
    cur_priv = p; mstatus_mie = mi; sstatus_sie = si;
    irq_pending = pe; irq_enable = en; irq_deleg = dl;
  endtask

  task automatic expect_out(input string req, input logic t, input logic [3:0] c, input logic [1:0] g);
    @(negedge clk);
    checks++;
    if (take_irq !== t || irq_cause !== c || target_priv !== g) begin
      failures++;
      $display("FAIL %s: got take=%0b cause=%0d target=%b, expected take=%0b cause=%0d target=%b",
               req, take_irq, irq_cause, target_priv, t, c, g);
    end
  endtask

  task automatic expect_model(input string req);
    logic t; logic [3:0] c; logic [1:0] g;
    model(t, c, g);
    expect_out(req, t, c, g);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      failures++;
      $display("FAIL watchdog: got cycles=%0d expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    // Idle state with every input at zero (R9).
    expect_out("R9 idle", 1'b0, 4'd0, 2'b00);
    // R4: S-mode, both globals off, undelegated timer source.
    drive(2'b01, 1'b0, 1'b0, 16'h0080, 16'h0080, 16'h0000);
    expect_out("R4 forced to M", 1'b1, 4'd7, 2'b11);
    // R1: M-mode follows mstatus_mie.
    drive(2'b11, 1'b0, 1'b1, 16'h0080, 16'h0080, 16'h0000);
    expect_out("R1 M closed", 1'b0, 4'd0, 2'b00);
    drive(2'b11, 1'b1, 1'b0, 16'h0080, 16'h0080, 16'h0000);
    expect_out("R1 M open", 1'b1, 4'd7, 2'b11);
    // R5: delegated source blocked in M even with everything on.
    drive(2'b11, 1'b1, 1'b1, 16'h0020, 16'h0020, 16'h0020);
    expect_out("R5 lower blocked", 1'b0, 4'd0, 2'b00);
    // R2 / R6: U-mode takes delegated source with sie 0 and 1.
    drive(2'b00, 1'b0, 1'b0, 16'h0020, 16'h0020, 16'h0020);
    expect_out("R6 U sie0", 1'b1, 4'd5, 2'b01);
    drive(2'b00, 1'b1, 1'b1, 16'h0020, 16'h0020, 16'h0020);
    expect_out("R6 U sie1", 1'b1, 4'd5, 2'b01);
    // R6: in M, toggling sie changes nothing for an undelegated source.
    drive(2'b11, 1'b1, 1'b0, 16'h0800, 16'h0800, 16'h0000);
    expect_out("R6 M sie0", 1'b1, 4'd11, 2'b11);
    drive(2'b11, 1'b1, 1'b1, 16'h0800, 16'h0800, 16'h0000);
    expect_out("R6 M sie1", 1'b1, 4'd11, 2'b11);
    // R2: S-mode follows sstatus_sie for delegated sources.
    drive(2'b01, 1'b1, 1'b0, 16'h0200, 16'h0200, 16'h0200);
    expect_out("R2 S closed", 1'b0, 4'd0, 2'b00);
    drive(2'b01, 1'b0, 1'b1, 16'h0200, 16'h0200, 16'h0200);
    expect_out("R2 S open", 1'b1, 4'd9, 2'b01);
    // R7: undelegated beats a higher-ranked delegated source.
    drive(2'b01, 1'b0, 1'b1, 16'h0A20, 16'h0A20, 16'h0800);
    expect_out("R7 group order", 1'b1, 4'd9, 2'b11);
    drive(2'b01, 1'b0, 1'b1, 16'h0202, 16'h0202, 16'h0200);
    expect_out("R7 undeleg wins", 1'b1, 4'd1, 2'b11);
    // R8: rank order inside each group.
    drive(2'b11, 1'b1, 1'b0, 16'h0888, 16'h0888, 16'h0000);
    expect_out("R8 11 first", 1'b1, 4'd11, 2'b11);
    drive(2'b11, 1'b1, 1'b0, 16'h0088, 16'h0088, 16'h0000);
    expect_out("R8 3 before 7", 1'b1, 4'd3, 2'b11);
    drive(2'b11, 1'b1, 1'b0, 16'h02A0, 16'h02A0, 16'h0000);
    expect_out("R8 7 before 9", 1'b1, 4'd7, 2'b11);
    drive(2'b00, 1'b0, 1'b0, 16'h0222, 16'h0222, 16'h0222);
    expect_out("R8 9 before 1", 1'b1, 4'd9, 2'b01);
    drive(2'b00, 1'b0, 1'b0, 16'h0022, 16'h0022, 16'h0022);
    expect_out("R8 1 before 5", 1'b1, 4'd1, 2'b01);
    // R3: pending without enable is ignored.
    drive(2'b00, 1'b1, 1'b1, 16'h0008, 16'h0000, 16'h0000);
    expect_out("R3 not enabled", 1'b0, 4'd0, 2'b00);
    drive(2'b00, 1'b1, 1'b1, 16'h0028, 16'h0008, 16'h0000);
    expect_out("R3 enabled only", 1'b1, 4'd3, 2'b11);
    // R10: non-standard bits never chosen, never block.
    drive(2'b00, 1'b1, 1'b1, 16'hF555, 16'hFFFF, 16'h0000);
    expect_out("R10 ignored", 1'b0, 4'd0, 2'b00);
    drive(2'b00, 1'b1, 1'b1, 16'hF575, 16'hFFFF, 16'h0000);
    expect_out("R10 no block", 1'b1, 4'd5, 2'b11);
    // Pseudo-random sweep against the model (R1, R2, R7, R8).
    for (int n = 0; n < N_RANDOM; n++) begin
      logic [15:0] pe;
      logic [15:0] en;
      pe = 16'($urandom) & 16'($urandom);
      en = 16'($urandom) | 16'($urandom);
      drive(2'($urandom), 1'($urandom), 1'($urandom), pe, en, 16'($urandom));
      expect_model("R1/R2/R7/R8 random");
    end
    finish_run();
  end

endmodule